// File: doc/BRIEF.md
# Dual-Issue Pairing Hazard Checker

This block sits at the issue stage of a core that fetches two 32-bit instructions as one 64-bit-aligned word. The upper half (bits 63:32) is the older instruction and the lower half (bits 31:0) is the younger. One instruction of a pair goes to the scalar/load-store slot and the other goes to the vector slot. The block decodes both halves and finds which vector registers and vector control registers each one reads or writes. It then decides whether the two may leave in the same cycle.

When the pair is unsafe, only the older instruction issues. The younger one is kept in a save register together with its transpose flag, and it issues alone in the following cycle. New input is ignored in that replay cycle. An external stall freezes the pending replay and blocks acceptance of new pairs. The decisions are registered, so they appear on the outputs one clock after the pair is presented.

Top module: `pair_issue_ctl`

## Requirements
- R1: After reset, `issue_o`, `xpose_o` and `replay_o` are all zero.
- R2: Class rule. A vector operation has opcode bits[31:26]=010010 with bit 25 set. Any other instruction is non-vector. Two valid instructions of the same class form an unsafe pair.
- R3: With no stall and no pending replay, the pair presented before a rising edge is reflected after that edge. `issue_o[1]` (older) equals its valid bit. `issue_o[0]` (younger) equals its valid bit unless the pair is unsafe. Vector operations encode vt in [20:16], vs in [15:11] and vd in [10:6]. Every vector operation except funct[5:0]=111000 (null op) reads vs and vt and writes vd.
- R4: A vector load (opcode 110010, register in [20:16], kind [14:11] not 1011) whose register equals the vs, vt or vd of the paired vector operation makes the pair unsafe, in either order.
- R5: A move to the vector unit (opcode 010010, [25:21]=00100, register in [15:11]) whose register equals vs, vt or vd makes the pair unsafe. So does a move from the vector unit ([25:21]=00000) whose register equals the paired vd. Both rules apply in either order.
- R6: A transpose load (kind [14:11]=1011) covers the aligned group of 8 registers that contains its base register, which means equal bits [4:3]. The pair is unsafe when vs, vt or vd lies in that group.
- R7: Control move-in ([25:21]=00110, control index in [15:11], indexes 0..2 only) makes the pair unsafe, in either order, when the vector operation reads that control register. funct[5:3]=000 reads c0, 010 reads c1, and 011 reads c0, c1 and c2.
- R8: Vector operations with funct[5:3]=001 or 011 write c0 and c1. Such an operation in the older slot, paired with a control move-out ([25:21]=00010) or control move-in of index 0 or 1 in the younger slot, is unsafe. The reverse order is safe.
- R9: A vector store (opcode 111010) or a wrapped vector load (opcode 110010, kind 1010) paired with a non-null vector operation is unsafe.
- R10: After an unsafe pair, the next unstalled cycle shows `issue_o`=01 with `replay_o`=1, and the input presented for that cycle is ignored.
- R11: While `stall_i` is high, the outputs after the edge are all zero, no new pair is accepted, and a pending replay is kept until the stall ends.
- R12: An instruction carries a transpose flag when bit 31 is 1 and bits[14:11]=1011. `xpose_o[k]` is 1 only when slot k issues with its flag set. A replayed instruction keeps its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_i | input | 64 | Fetch word: [63:32] older, [31:0] younger |
| slot_vld_i | input | 2 | Valid: bit 1 older, bit 0 younger |
| stall_i | input | 1 | Stall: freezes replay, refuses new pairs |
| issue_o | output | 2 | Issue enable: bit 1 older slot, bit 0 younger slot |
| xpose_o | output | 2 | Transpose flag of each issuing slot |
| replay_o | output | 1 | The issuing younger instruction is a saved replay |

## Verification
Several properties are checked on every cycle against the registered outputs and the pending state. A detected conflict on an accepted pair kills the younger slot. A replay always issues alone and never twice in a row. A stall yields silent outputs and holds the pending replay. A transpose flag never appears on a slot that does not issue. Only the bench scenarios can show that each decode rule fires on the correct register or control fields. These scenarios also show the order dependence of the flag-write rule, the group-of-eight compare for transpose loads, and that input offered during a replay cycle is really dropped. The bench covers these with directed pairs and with random pairs compared against a behavioural model.

// File: rtl/pair_pkg.sv
package pair_pkg;
    localparam int INST_W   = 32;
    localparam int REG_W    = 5;
    localparam int NUM_VC   = 3;
    localparam int GRP_LOG2 = 3;
    localparam int GRP_W    = REG_W - GRP_LOG2;
    localparam int SLOTS    = 2;

    localparam logic [5:0] OP_COP = 6'b010010;
    localparam logic [5:0] OP_VLD = 6'b110010;
    localparam logic [5:0] OP_VST = 6'b111010;

    localparam logic [4:0] MV_FROM_V  = 5'b00000;
    localparam logic [4:0] MV_FROM_C  = 5'b00010;
    localparam logic [4:0] MV_TO_V    = 5'b00100;
    localparam logic [4:0] MV_TO_C    = 5'b00110;

    localparam logic [3:0] KIND_XPOSE = 4'b1011;
    localparam logic [3:0] KIND_WRAP  = 4'b1010;

    localparam logic [2:0] GRP_ARITH  = 3'b000;
    localparam logic [2:0] GRP_CMP    = 3'b001;
    localparam logic [2:0] GRP_MERGE  = 3'b010;
    localparam logic [2:0] GRP_CLIP   = 3'b011;
    localparam logic [5:0] FN_NULL    = 6'b111000;

    typedef logic [REG_W-1:0]  vreg_t;
    typedef logic [NUM_VC-1:0] vcmask_t;

    typedef struct packed {
        logic    vop;
        logic    vnull;
        logic    vld;
        logic    vst;
        logic    ltv;
        logic    lwv;
        logic    mtv;
        logic    mfv;
        logic    mtc;
        logic    mfc;
        logic    xp;
        vreg_t   vt;
        vreg_t   vs;
        vreg_t   vd;
        vreg_t   mreg;
        vcmask_t vc_rd;
        vcmask_t vc_wr;
        vcmask_t cc_sel;
    } dec_t;

    typedef struct packed {
        logic             pend;
        logic             sav_xp;
        logic [SLOTS-1:0] issue;
        logic [SLOTS-1:0] xpose;
        logic             replay;
    } ctl_t;
endpackage

// File: rtl/pair_decode.sv
module pair_decode
    import pair_pkg::*;
(
    input  logic [INST_W-1:0] inst_i,
    output dec_t              dec_o
);
    logic [5:0] opc;
    logic [4:0] sub;
    logic [3:0] kind;
    logic [5:0] fn;

    always_comb begin
        opc  = inst_i[INST_W-1 -: 6];
        sub  = inst_i[25:21];
        kind = inst_i[14:11];
        fn   = inst_i[5:0];

        dec_o    = '0;
        dec_o.xp = inst_i[31] && (kind == KIND_XPOSE);
        dec_o.vt = inst_i[20:16];
        dec_o.vs = inst_i[15:11];
        dec_o.vd = inst_i[10:6];

        if (opc == OP_COP && inst_i[25]) begin
            dec_o.vop   = 1'b1;
            dec_o.vnull = (fn == FN_NULL);
            unique case (fn[5:3])
                GRP_ARITH: dec_o.vc_rd = 3'b001;
                GRP_CMP:   dec_o.vc_wr = 3'b011;
                GRP_MERGE: dec_o.vc_rd = 3'b010;
                GRP_CLIP: begin
                    dec_o.vc_rd = 3'b111;
                    dec_o.vc_wr = 3'b011;
                end
                default: begin
                    dec_o.vc_rd = '0;
                    dec_o.vc_wr = '0;
                end
            endcase
        end else if (opc == OP_COP) begin
            dec_o.mreg = inst_i[15:11];
            unique case (sub)
                MV_FROM_V: dec_o.mfv = 1'b1;
                MV_FROM_C: dec_o.mfc = 1'b1;
                MV_TO_V:   dec_o.mtv = 1'b1;
                MV_TO_C:   dec_o.mtc = 1'b1;
                default:   dec_o.mfv = 1'b0;
            endcase
            for (int k = 0; k < NUM_VC; k++) begin
                dec_o.cc_sel[k] = (inst_i[15:11] == vreg_t'(k));
            end
        end else if (opc == OP_VLD) begin
            dec_o.vld  = 1'b1;
            dec_o.mreg = inst_i[20:16];
            dec_o.ltv  = (kind == KIND_XPOSE);
            dec_o.lwv  = (kind == KIND_WRAP);
        end else if (opc == OP_VST) begin
            dec_o.vst  = 1'b1;
            dec_o.mreg = inst_i[20:16];
        end
    end
endmodule

// File: rtl/pair_rule.sv
module pair_rule
    import pair_pkg::*;
#(
    parameter bit VEC_FIRST = 1'b1
) (
    input  dec_t vec_i,
    input  dec_t other_i,
    output logic hit_o
);
    logic applies;
    logic reg_use;
    logic grp_use;
    logic h_load, h_mtv, h_mfv, h_xpose, h_ctl_rd, h_flag_wr, h_mem;
    logic unused_fields;

    assign unused_fields = ^{vec_i, other_i};

    always_comb begin
        applies = vec_i.vop && !vec_i.vnull && !other_i.vop;

        reg_use = (other_i.mreg == vec_i.vs) ||
                  (other_i.mreg == vec_i.vt) ||
                  (other_i.mreg == vec_i.vd);

        grp_use = (other_i.mreg[REG_W-1 -: GRP_W] == vec_i.vs[REG_W-1 -: GRP_W]) ||
                  (other_i.mreg[REG_W-1 -: GRP_W] == vec_i.vt[REG_W-1 -: GRP_W]) ||
                  (other_i.mreg[REG_W-1 -: GRP_W] == vec_i.vd[REG_W-1 -: GRP_W]);

        h_load    = other_i.vld && !other_i.ltv && reg_use;
        h_mtv     = other_i.mtv && reg_use;
        h_mfv     = other_i.mfv && (other_i.mreg == vec_i.vd);
        h_xpose   = other_i.ltv && grp_use;
        h_ctl_rd  = other_i.mtc && |(other_i.cc_sel & vec_i.vc_rd);
        h_flag_wr = VEC_FIRST && (other_i.mfc || other_i.mtc) &&
                    |(other_i.cc_sel & vec_i.vc_wr);
        h_mem     = other_i.vst || other_i.lwv;

        hit_o = applies && (h_load || h_mtv || h_mfv || h_xpose ||
                            h_ctl_rd || h_flag_wr || h_mem);
    end
endmodule

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
(
    input  dec_t             fst_i,
    input  dec_t             snd_i,
    input  logic [SLOTS-1:0] vld_i,
    output logic             conflict_o
);
    logic hit_vec_fst;
    logic hit_vec_snd;
    logic same_class;

    pair_rule #(.VEC_FIRST(1'b1)) u_vec_fst (
        .vec_i   (fst_i),
        .other_i (snd_i),
        .hit_o   (hit_vec_fst)
    );

    pair_rule #(.VEC_FIRST(1'b0)) u_vec_snd (
        .vec_i   (snd_i),
        .other_i (fst_i),
        .hit_o   (hit_vec_snd)
    );

    always_comb begin
        same_class = (fst_i.vop == snd_i.vop);
        conflict_o = (&vld_i) && (same_class || hit_vec_fst || hit_vec_snd);
    end
endmodule

// File: rtl/pair_issue_ctl.sv
module pair_issue_ctl
    import pair_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [SLOTS*INST_W-1:0] fetch_i,
    input  logic [SLOTS-1:0]       slot_vld_i,
    input  logic                   stall_i,
    output logic [SLOTS-1:0]       issue_o,
    output logic [SLOTS-1:0]       xpose_o,
    output logic                   replay_o
);
    localparam int OLD = SLOTS - 1;
    localparam int YNG = 0;

    dec_t dec [SLOTS];
    logic pair_conflict;
    logic pend_w;
    ctl_t st_d, st_q;

    for (genvar g = 0; g < SLOTS; g++) begin : g_dec
        pair_decode u_dec (
            .inst_i (fetch_i[g*INST_W +: INST_W]),
            .dec_o  (dec[g])
        );
    end

    pair_hazard u_haz (
        .fst_i      (dec[OLD]),
        .snd_i      (dec[YNG]),
        .vld_i      (slot_vld_i),
        .conflict_o (pair_conflict)
    );

    always_comb begin
        st_d        = st_q;
        st_d.issue  = '0;
        st_d.xpose  = '0;
        st_d.replay = 1'b0;
        if (stall_i) begin
            st_d.pend   = st_q.pend;
            st_d.sav_xp = st_q.sav_xp;
        end else if (st_q.pend) begin
            st_d.issue[YNG] = 1'b1;
            st_d.xpose[YNG] = st_q.sav_xp;
            st_d.replay     = 1'b1;
            st_d.pend       = 1'b0;
        end else begin
            st_d.issue[OLD] = slot_vld_i[OLD];
            st_d.issue[YNG] = slot_vld_i[YNG] && !pair_conflict;
            st_d.xpose[OLD] = slot_vld_i[OLD] && dec[OLD].xp;
            st_d.xpose[YNG] = st_d.issue[YNG] && dec[YNG].xp;
            st_d.pend       = pair_conflict;
            st_d.sav_xp     = dec[YNG].xp;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_o  = st_q.issue;
    assign xpose_o  = st_q.xpose;
    assign replay_o = st_q.replay;
    assign pend_w   = st_q.pend;
endmodule

// File: rtl/pair_issue_chk.sv
module pair_issue_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       stall_i,
    input logic [1:0] issue_o,
    input logic [1:0] xpose_o,
    input logic       replay_o,
    input logic       pend_i,
    input logic       conflict_i
);
    AST_KILL_YOUNGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (conflict_i && !stall_i && !pend_i) |=> (issue_o == 2'b10)); // R2

    AST_REPLAY_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        replay_o |-> (issue_o == 2'b01)); // R10

    AST_NO_REPLAY_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        replay_o |=> !replay_o); // R10

    AST_PEND_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_i && !stall_i) |=> replay_o); // R10

    AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> (issue_o == 2'b00 && !replay_o)); // R11

    AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_i && pend_i) |=> pend_i); // R11

    AST_XP_NEEDS_ISSUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (xpose_o & ~issue_o) == 2'b00); // R12
endmodule

bind pair_issue_ctl pair_issue_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stall_i    (stall_i),
    .issue_o    (issue_o),
    .xpose_o    (xpose_o),
    .replay_o   (replay_o),
    .pend_i     (pend_w),
    .conflict_i (pair_conflict)
);

// File: tb/pair_issue_ctl_tb.sv
module pair_issue_ctl_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] fetch = '0;
    logic [1:0]  vld = '0;
    logic        stall = 1'b0;
    logic [1:0]  issue_o, xpose_o;
    logic        replay_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0] m_issue = '0, m_xp = '0;
    logic       m_rep = 1'b0, m_pend = 1'b0, m_savxp = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pair_issue_ctl u_dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .fetch_i    (fetch),
        .slot_vld_i (vld),
        .stall_i    (stall),
        .issue_o    (issue_o),
        .xpose_o    (xpose_o),
        .replay_o   (replay_o)
    );

    // instruction builders
    function automatic logic [31:0] vop(logic [5:0] fn, logic [4:0] vd, logic [4:0] vs, logic [4:0] vt);
        return {6'b010010, 5'b10000, vt, vs, vd, fn};
    endfunction
    function automatic logic [31:0] mv(logic [4:0] sub, logic [4:0] r);
        return {6'b010010, sub, 5'd1, r, 11'd0};
    endfunction
    function automatic logic [31:0] ld(logic [3:0] kind, logic [4:0] r);
        return {6'b110010, 5'd0, r, 1'b0, kind, 11'd0};
    endfunction
    function automatic logic [31:0] st(logic [3:0] kind, logic [4:0] r);
        return {6'b111010, 5'd0, r, 1'b0, kind, 11'd0};
    endfunction
    localparam logic [31:0] NOP = 32'h0;

    // behavioural reference
    function automatic bit is_vec(logic [31:0] w);
        return (w[31:26] == 6'b010010) && w[25];
    endfunction
    function automatic bit has_xp(logic [31:0] w);
        return w[31] && (w[14:11] == 4'b1011);
    endfunction
    function automatic bit touches(logic [31:0] v, logic [4:0] r);
        return (v[20:16] == r) || (v[15:11] == r) || (v[10:6] == r);
    endfunction
    function automatic bit rule(logic [31:0] v, logic [31:0] o, bit vfirst);
        int g;
        bit rd0, rd1, rd2, wr01, hit;
        logic [4:0] c;
        if (!is_vec(v) || is_vec(o) || v[5:0] == 6'b111000) return 0;
        g    = int'(v[5:3]);
        rd0  = (g == 0) || (g == 3);
        rd1  = (g == 2) || (g == 3);
        rd2  = (g == 3);
        wr01 = (g == 1) || (g == 3);
        hit  = 0;
        c    = o[15:11];
        if (o[31:26] == 6'b110010) begin
            if (o[14:11] == 4'b1011)
                hit = (v[20:19] == o[20:19]) || (v[15:14] == o[20:19]) || (v[10:9] == o[20:19]);
            else
                hit = touches(v, o[20:16]) || (o[14:11] == 4'b1010);
        end else if (o[31:26] == 6'b111010) begin
            hit = 1;
        end else if (o[31:26] == 6'b010010) begin
            case (o[25:21])
                5'b00000: hit = (v[10:6] == c);
                5'b00100: hit = touches(v, c);
                5'b00110: hit = (c == 0 && rd0) || (c == 1 && rd1) || (c == 2 && rd2) ||
                                (vfirst && wr01 && c < 2);
                5'b00010: hit = vfirst && wr01 && c < 2;
                default:  hit = 0;
            endcase
        end
        return hit;
    endfunction
    function automatic bit unsafe(logic [31:0] a, logic [31:0] b);
        return (is_vec(a) == is_vec(b)) || rule(a, b, 1) || rule(b, a, 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_issue = '0; m_xp = '0; m_rep = 0; m_pend = 0; m_savxp = 0;
        end else if (stall) begin
            m_issue = '0; m_xp = '0; m_rep = 0;
        end else if (m_pend) begin
            m_issue = 2'b01; m_xp = {1'b0, m_savxp}; m_rep = 1; m_pend = 0;
        end else begin
            bit c;
            c = (vld == 2'b11) && unsafe(fetch[63:32], fetch[31:0]);
            m_issue = {vld[1], vld[0] && !c};
            m_xp    = {vld[1] && has_xp(fetch[63:32]), vld[0] && !c && has_xp(fetch[31:0])};
            m_rep   = 0;
            m_pend  = c;
            if (c) m_savxp = has_xp(fetch[31:0]);
        end
    end

    task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b (issue,xpose,replay)", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge and compare with the model
    task automatic step(logic [31:0] a, logic [31:0] b, logic [1:0] v, logic s, string tag);
        fetch = {a, b};
        vld   = v;
        stall = s;
        @(negedge clk);
        chk({tag, "/model"}, {issue_o, xpose_o, replay_o}, {m_issue, m_xp, m_rep});
    endtask

    task automatic expect5(string tag, logic [4:0] exp);
        chk(tag, {issue_o, xpose_o, replay_o}, exp);
    endtask

    task automatic idle(string tag, logic [4:0] exp);
        step(NOP, NOP, 2'b00, 1'b0, tag);
        expect5(tag, exp);
    endtask

    function automatic logic [31:0] rnd_inst();
        logic [4:0] r1, r2, r3;
        r1 = 5'($urandom_range(0, 11));
        r2 = 5'($urandom_range(0, 11));
        r3 = 5'($urandom_range(0, 11));
        case ($urandom_range(0, 8))
            0: return vop({3'($urandom_range(0, 3)), 3'b000}, r1, r2, r3);
            1: return vop(6'b111000, r1, r2, r3);
            2: return ld($urandom_range(0, 1) ? 4'b1011 : 4'b0100, r1);
            3: return ld(4'b1010, r1);
            4: return st($urandom_range(0, 1) ? 4'b1011 : 4'b0100, r1);
            5: return mv(5'b00100, r1);
            6: return mv(5'b00000, r1);
            7: return mv($urandom_range(0, 1) ? 5'b00110 : 5'b00010, 5'($urandom_range(0, 3)));
            default: return NOP;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    logic [31:0] ADD, CLIP, CMP, VNUL;
    initial begin
        ADD  = vop(6'b000000, 5'd3, 5'd5, 5'd2);
        CLIP = vop(6'b011000, 5'd3, 5'd5, 5'd2);
        CMP  = vop(6'b001000, 5'd3, 5'd5, 5'd2);
        VNUL = vop(6'b111000, 5'd3, 5'd5, 5'd2);

        repeat (3) @(negedge clk);
        expect5("R1", 5'b00000);
        rst_n = 1'b1;

        // R3 basic pairing and valid bits
        step(ADD, NOP, 2'b11, 0, "R3"); expect5("R3", 5'b11000);
        step(NOP, ADD, 2'b11, 0, "R3"); expect5("R3", 5'b11000);
        step(NOP, ADD, 2'b01, 0, "R3"); expect5("R3", 5'b01000);
        idle("R3", 5'b00000);

        // R2 class clash, R10 replay ignores input
        step(NOP, NOP, 2'b11, 0, "R2"); expect5("R2", 5'b10000);
        step(ADD, NOP, 2'b11, 0, "R10"); expect5("R10", 5'b01001);
        idle("R10", 5'b00000);
        step(ADD, VNUL, 2'b11, 0, "R2"); expect5("R2", 5'b10000);
        idle("R10", 5'b01001);

        // R4 vector load
        step(ld(4'b0100, 5'd5), ADD, 2'b11, 0, "R4"); expect5("R4", 5'b10000);
        idle("R4", 5'b01001);
        step(ADD, ld(4'b0100, 5'd3), 2'b11, 0, "R4"); expect5("R4", 5'b10000);
        idle("R4", 5'b01001);
        step(ld(4'b0100, 5'd9), ADD, 2'b11, 0, "R4"); expect5("R4", 5'b11000);

        // R5 moves
        step(mv(5'b00100, 5'd2), ADD, 2'b11, 0, "R5"); expect5("R5", 5'b10000);
        idle("R5", 5'b01001);
        step(ADD, mv(5'b00000, 5'd3), 2'b11, 0, "R5"); expect5("R5", 5'b10000);
        idle("R5", 5'b01001);
        step(ADD, mv(5'b00000, 5'd5), 2'b11, 0, "R5"); expect5("R5", 5'b11000);

        // R6 transpose group
        step(ld(4'b1011, 5'd8), vop(6'b000000, 5'd1, 5'd13, 5'd2), 2'b11, 0, "R6");
        expect5("R6", 5'b10100);
        idle("R6", 5'b01001);
        step(ld(4'b1011, 5'd8), vop(6'b000000, 5'd7, 5'd16, 5'd0), 2'b11, 0, "R6");
        expect5("R6", 5'b11100);

        // R7 control move-in vs control read
        step(mv(5'b00110, 5'd2), CLIP, 2'b11, 0, "R7"); expect5("R7", 5'b10000);
        idle("R7", 5'b01001);
        step(mv(5'b00110, 5'd2), ADD, 2'b11, 0, "R7"); expect5("R7", 5'b11000);
        step(ADD, mv(5'b00110, 5'd0), 2'b11, 0, "R7"); expect5("R7", 5'b10000);
        idle("R7", 5'b01001);

        // R8 ordered flag write
        step(CMP, mv(5'b00010, 5'd1), 2'b11, 0, "R8"); expect5("R8", 5'b10000);
        idle("R8", 5'b01001);
        step(mv(5'b00010, 5'd1), CMP, 2'b11, 0, "R8"); expect5("R8", 5'b11000);

        // R9 store / wrapped load
        step(ADD, st(4'b0100, 5'd20), 2'b11, 0, "R9"); expect5("R9", 5'b10000);
        idle("R9", 5'b01001);
        step(ld(4'b1010, 5'd20), ADD, 2'b11, 0, "R9"); expect5("R9", 5'b10000);
        idle("R9", 5'b01001);
        step(VNUL, st(4'b0100, 5'd3), 2'b11, 0, "R9"); expect5("R9", 5'b11000);

        // R11 stall
        step(NOP, NOP, 2'b11, 0, "R11"); expect5("R11", 5'b10000);
        step(ADD, NOP, 2'b11, 1, "R11"); expect5("R11", 5'b00000);
        step(ADD, NOP, 2'b11, 1, "R11"); expect5("R11", 5'b00000);
        idle("R11", 5'b01001);
        step(ADD, NOP, 2'b11, 1, "R11"); expect5("R11", 5'b00000);
        idle("R11", 5'b00000);

        // R12 saved transpose flag
        step(ADD, st(4'b1011, 5'd4), 2'b11, 0, "R12"); expect5("R12", 5'b10000);
        idle("R12", 5'b01011);

        // random pairs against the model
        for (int i = 0; i < 400; i++) begin
            step(rnd_inst(), rnd_inst(), 2'($urandom_range(0, 3)),
                 ($urandom_range(0, 7) == 0), "rand");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule